// File: doc/BRIEF.md
# Multiframe Signaling Bit Capture

This block watches a serial signaling stream that runs beside a time-slotted data stream. Each slot of the signaling stream holds the four-bit ABCD signaling state of the data slot at the same position. The surrounding timebase supplies a bit strobe, the current slot index, the bit position within the slot and a flag that marks the first frame of the multiframe.

During that first frame the block assembles the four signaling bits of every slot and stores them in a register array with one entry per slot. In every other frame the stored states are held unchanged. Downstream logic reads any entry through a combinational read port.

An entry is only written when all four signaling bits of one slot were received in order, in the first frame, and under the same slot index. A slot that is cut short, or whose index changes partway, leaves the old value in place.

Top module: `sigcap_top`

## Requirements
- R1: A synchronous active-low reset clears every entry to 4'b0000; after reset every slot reads 4'b0000.
- R2: Bit positions count from 0 (first bit of a slot) to 7 (last). The signaling bits are taken from positions 4, 5, 6 and 7 as A, B, C and D. A appears on rd_abcd[3] and D on rd_abcd[0]. Positions 0 to 3 have no effect on the entry.
- R3: Entries are written only while first_frame is 1. Beats received while first_frame is 0 leave every entry unchanged.
- R4: An entry is written on the clock edge of its position-7 beat and can be read from the next cycle on. Writing one slot leaves all other slots unchanged.
- R5: If any of positions 4 to 7 of a slot is missing in the first frame, or if the slot index changes between them, that slot's entry keeps its old value.
- R6: Cycles with bit_en at 0 are ignored, whatever the other inputs hold. Beats of one slot may be separated by such idle cycles and the slot is still captured.
- R7: rd_abcd shows the entry selected by rd_slot in the same cycle, with no register in the read path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | Marks a cycle that carries one signaling bit |
| sig_bit | input | 1 | Serial signaling bit |
| slot_idx | input | 5 | Index of the slot the current bit belongs to |
| bit_pos | input | 3 | Position of the current bit within its slot, 0 first |
| first_frame | input | 1 | High throughout the first frame of a multiframe |
| rd_slot | input | 5 | Slot selected on the read port |
| rd_abcd | output | 4 | Stored ABCD state of the selected slot, A in bit 3 |

## Verification
On every cycle the assertions check that a store write happens only on a first-frame position-7 beat. They also check that the read value stays put when no write has occurred and the read address is steady, that a written value appears on the read port one cycle later, and that reset leaves the array cleared. Only the bench's scenarios can show that the right bit positions land in the right ABCD order. The same holds for interrupted slots, slot-index changes and idle gaps, and for a whole multiframe of non-first frames leaving all 32 entries intact.

// File: rtl/sigcap_pkg.sv
// Shared constants and types for the signaling capture block.
// Assumes the signaling state is always four bits (A, B, C, D).
package sigcap_pkg;
    localparam int SIG_W = 4;
    typedef logic [SIG_W-1:0] abcd_t;
endpackage

// File: rtl/sigcap_assembler.sv
// Collects the four signaling bits of one slot during the first frame and
// issues a single write strobe on the last of them.
// Assumes bit positions arrive in increasing order within a slot and that
// the signaling bits occupy the last SIG_W positions of the slot.
module sigcap_assembler
    import sigcap_pkg::*;
#(
    parameter int SLOT_W    = 5,
    parameter int SLOT_BITS = 8,
    parameter int POS_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              sig_bit,
    input  logic [SLOT_W-1:0] slot_idx,
    input  logic [POS_W-1:0]  bit_pos,
    input  logic              first_frame,
    output logic              wr_en,
    output logic [SLOT_W-1:0] wr_slot,
    output abcd_t             wr_data
);
    localparam int FIRST_POS = SLOT_BITS - SIG_W;
    localparam logic [POS_W-1:0] FIRST_P = POS_W'(FIRST_POS);
    localparam logic [POS_W-1:0] LAST_K  = POS_W'(SIG_W - 1);

    logic [SIG_W-2:0]  hold_q;
    logic [POS_W-1:0]  cnt_q;
    logic [SLOT_W-1:0] slot_q;

    logic              in_sig;
    logic [POS_W-1:0]  k;
    logic              beat;
    logic              chain_ok;

    // Decode the current beat: offset within the signaling field and continuity.
    always_comb begin
        in_sig   = (bit_pos >= FIRST_P);
        k        = bit_pos - FIRST_P;
        beat     = bit_en && first_frame && in_sig;
        chain_ok = (k == '0) || ((slot_idx == slot_q) && (cnt_q == k));
    end

    // Write strobe and data for the store.
    always_comb begin
        wr_en   = beat && chain_ok && (k == LAST_K);
        wr_slot = slot_idx;
        wr_data = {hold_q, sig_bit};
    end

    // Track how many signaling bits of the current slot are held so far.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            hold_q <= '0;
            slot_q <= '0;
        end else if (bit_en) begin
            if (beat && chain_ok && (k != LAST_K)) begin
                cnt_q  <= k + POS_W'(1);
                hold_q <= {hold_q[SIG_W-3:0], sig_bit};
                slot_q <= slot_idx;
            end else begin
                cnt_q  <= '0;
            end
        end
    end
endmodule

// File: rtl/sigcap_store.sv
// Per-slot signaling state array with one write port and a combinational
// read port. Assumes at most one write per cycle.
module sigcap_store
    import sigcap_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  abcd_t             wr_data,
    input  logic [SLOT_W-1:0] rd_slot,
    output abcd_t             rd_data
);
    abcd_t entry_q [NUM_SLOTS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_entry
        // Hold one slot's state; load it when the write targets this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                entry_q[g] <= '0;
            else if (wr_en && (wr_slot == SLOT_W'(g)))
                entry_q[g] <= wr_data;
        end
    end

    // Select the addressed entry; out-of-range addresses read as zero.
    always_comb begin
        rd_data = '0;
        if (int'(rd_slot) < NUM_SLOTS)
            rd_data = entry_q[rd_slot];
    end
endmodule

// File: rtl/sigcap_top.sv
// Top of the multiframe signaling capture block: assembles ABCD bits in the
// first frame and keeps them per slot. Assumes the timebase delivers slot
// index, bit position and first-frame flag aligned with each bit.
module sigcap_top
    import sigcap_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_BITS = 8,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int POS_W    = $clog2(SLOT_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              sig_bit,
    input  logic [SLOT_W-1:0] slot_idx,
    input  logic [POS_W-1:0]  bit_pos,
    input  logic              first_frame,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [SIG_W-1:0]  rd_abcd
);
    logic              wr_en;
    logic [SLOT_W-1:0] wr_slot;
    abcd_t             wr_data;

    sigcap_assembler #(
        .SLOT_W(SLOT_W), .SLOT_BITS(SLOT_BITS), .POS_W(POS_W)
    ) u_asm (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sig_bit(sig_bit),
        .slot_idx(slot_idx), .bit_pos(bit_pos), .first_frame(first_frame),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_data(wr_data)
    );

    sigcap_store #(
        .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot),
        .wr_data(wr_data), .rd_slot(rd_slot), .rd_data(rd_abcd)
    );
endmodule

// File: rtl/sigcap_checker.sv
// Cycle-level properties of the signaling capture block, bound to its top.
module sigcap_checker #(
    parameter int SLOT_W = 5,
    parameter int POS_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_en,
    input logic              first_frame,
    input logic [POS_W-1:0]  bit_pos,
    input logic              wr_en,
    input logic [SLOT_W-1:0] wr_slot,
    input logic [3:0]        wr_data,
    input logic [SLOT_W-1:0] rd_slot,
    input logic [3:0]        rd_abcd
);
    // R3, R4: writes only on a first-frame beat at the last bit position
    assert_write_first_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (bit_en && first_frame && (bit_pos == '1)));

    // R4: a written entry is visible on the next cycle
    assert_write_visible_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (rd_slot == wr_slot)) ##1 $stable(rd_slot) |-> (rd_abcd == $past(wr_data)));

    // R3, R7: without a write and with a steady address the read value holds
    assert_hold_without_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) ##1 $stable(rd_slot) |-> $stable(rd_abcd));

    // R1: reset leaves the array cleared
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (rd_abcd == 4'b0000));
endmodule

bind sigcap_top sigcap_checker #(.SLOT_W(SLOT_W), .POS_W(POS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .first_frame(first_frame),
    .bit_pos(bit_pos), .wr_en(wr_en), .wr_slot(wr_slot), .wr_data(wr_data),
    .rd_slot(rd_slot), .rd_abcd(rd_abcd)
);

// File: tb/tb_sigcap_top.sv
// Directed bench for sigcap_top: one task per scenario, each checking itself.
module tb_sigcap_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       sig_bit = 1'b0;
    logic [4:0] slot_idx = '0;
    logic [2:0] bit_pos = '0;
    logic       first_frame = 1'b0;
    logic [4:0] rd_slot = '0;
    logic [3:0] rd_abcd;

    int n_tests = 0;
    int n_fail  = 0;
    logic [3:0] exp_q [32];

    always #5 clk = ~clk;

    sigcap_top dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sig_bit(sig_bit),
        .slot_idx(slot_idx), .bit_pos(bit_pos), .first_frame(first_frame),
        .rd_slot(rd_slot), .rd_abcd(rd_abcd)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // One cycle of input, driven on the falling edge.
    task automatic beat(input logic en, input logic [4:0] s, input logic [2:0] p,
                        input logic b, input logic ff);
        @(negedge clk);
        bit_en = en; slot_idx = s; bit_pos = p; sig_bit = b; first_frame = ff;
    endtask

    task automatic idle();
        beat(1'b0, 5'd0, 3'd0, 1'b0, 1'b0);
    endtask

    // A whole slot, bit at position p is val[7-p]; low nibble is the ABCD state.
    task automatic send_slot(input logic [4:0] s, input logic [7:0] val, input logic ff);
        for (int p = 0; p < 8; p++)
            beat(1'b1, s, 3'(p), val[7-p], ff);
    endtask

    task automatic send_frame(input logic ff, input int seed);
        for (int s = 0; s < 32; s++) begin
            logic [7:0] v;
            v = 8'(s * 37 + seed * 11 + 5);
            send_slot(5'(s), v, ff);
            if (ff) exp_q[s] = v[3:0];
        end
        idle();
    endtask

    task automatic read_all(input string req);
        for (int s = 0; s < 32; s++) begin
            @(negedge clk);
            rd_slot = 5'(s);
            #1 check(req, rd_abcd, exp_q[s]);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(); idle();
        rst_n = 1'b1;
        for (int s = 0; s < 32; s++) exp_q[s] = 4'b0000;
    endtask

    task automatic t_reset();
        do_reset();
        read_all("R1 reset state");
    endtask

    task automatic t_first_frame();
        send_frame(1'b1, 1);
        read_all("R2/R4 first-frame capture");
    endtask

    task automatic t_other_frames();
        for (int f = 0; f < 3; f++) send_frame(1'b0, 20 + f);
        read_all("R3 non-first frames hold");
        send_frame(1'b1, 7);
        read_all("R3 next multiframe update");
    endtask

    task automatic t_bit_order();
        // high nibble differs only: entry must equal low nibble, A in bit 3
        send_slot(5'd4, 8'b1111_1000, 1'b1); exp_q[4] = 4'b1000;
        send_slot(5'd5, 8'b0000_0001, 1'b1); exp_q[5] = 4'b0001;
        send_slot(5'd6, 8'b1010_0110, 1'b1); exp_q[6] = 4'b0110;
        idle();
        @(negedge clk); rd_slot = 5'd4; #1 check("R2 A in bit3", rd_abcd, exp_q[4]);
        @(negedge clk); rd_slot = 5'd5; #1 check("R2 D in bit0", rd_abcd, exp_q[5]);
        @(negedge clk); rd_slot = 5'd6; #1 check("R2 upper positions ignored", rd_abcd, exp_q[6]);
        @(negedge clk); rd_slot = 5'd7; #1 check("R4 neighbour untouched", rd_abcd, exp_q[7]);
    endtask

    task automatic t_write_timing();
        // R4: value not yet visible during the last beat, visible right after
        rd_slot = 5'd10;
        for (int p = 0; p < 7; p++) beat(1'b1, 5'd10, 3'(p), p[0], 1'b1);
        beat(1'b1, 5'd10, 3'd7, 1'b1, 1'b1);
        #1 check("R4 old value during last beat", rd_abcd, exp_q[10]);
        exp_q[10] = 4'b0101;
        idle();
        #1 check("R4 new value next cycle", rd_abcd, exp_q[10]);
    endtask

    task automatic t_incomplete();
        // first_frame drops before positions 6 and 7
        for (int p = 0; p < 6; p++) beat(1'b1, 5'd3, 3'(p), 1'b1, 1'b1);
        beat(1'b1, 5'd3, 3'd6, 1'b1, 1'b0);
        beat(1'b1, 5'd3, 3'd7, 1'b1, 1'b0);
        // slot index changes before position 7
        for (int p = 0; p < 7; p++) beat(1'b1, 5'd12, 3'(p), ~exp_q[12][0], 1'b1);
        beat(1'b1, 5'd13, 3'd7, ~exp_q[13][0], 1'b1);
        // position 4 missing
        for (int p = 5; p < 8; p++) beat(1'b1, 5'd9, 3'(p), ~exp_q[9][0], 1'b1);
        idle();
        @(negedge clk); rd_slot = 5'd3;  #1 check("R5 frame ended mid-slot", rd_abcd, exp_q[3]);
        @(negedge clk); rd_slot = 5'd12; #1 check("R5 index change first slot", rd_abcd, exp_q[12]);
        @(negedge clk); rd_slot = 5'd13; #1 check("R5 index change second slot", rd_abcd, exp_q[13]);
        @(negedge clk); rd_slot = 5'd9;  #1 check("R5 missing position 4", rd_abcd, exp_q[9]);
    endtask

    task automatic t_gaps();
        // idle cycles with garbage between beats of slot 20; final value 4'b1001
        logic [7:0] v;
        v = 8'b0110_1001;
        for (int p = 0; p < 8; p++) begin
            beat(1'b1, 5'd20, 3'(p), v[7-p], 1'b1);
            beat(1'b0, 5'd21, 3'd7, 1'b1, 1'b1);
        end
        exp_q[20] = 4'b1001;
        // a lone disabled last-position cycle for slot 22
        beat(1'b0, 5'd22, 3'd7, ~exp_q[22][3], 1'b1);
        idle();
        @(negedge clk); rd_slot = 5'd20; #1 check("R6 gaps inside slot", rd_abcd, exp_q[20]);
        @(negedge clk); rd_slot = 5'd21; #1 check("R6 idle cycles ignored", rd_abcd, exp_q[21]);
        @(negedge clk); rd_slot = 5'd22; #1 check("R6 disabled beat ignored", rd_abcd, exp_q[22]);
    endtask

    task automatic t_read_port();
        // R7: address change reflects in the same cycle, no write needed
        @(negedge clk);
        rd_slot = 5'd0;  #1 check("R7 read slot 0", rd_abcd, exp_q[0]);
        rd_slot = 5'd31; #1 check("R7 read slot 31", rd_abcd, exp_q[31]);
        rd_slot = 5'd20; #1 check("R7 read slot 20", rd_abcd, exp_q[20]);
    endtask

    task automatic t_reset_again();
        do_reset();
        read_all("R1 reset after data");
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_first_frame();
                t_other_frames();
                t_bit_order();
                t_write_timing();
                t_incomplete();
                t_gaps();
                t_read_port();
                t_reset_again();
            end
            begin
                repeat (50000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule